// File: doc/BRIEF.md
# Command-Word to Memory-Bus Bridge

This block sits on the terminal side of a command/response serial bus of the dual-redundant avionics kind. It does not touch line coding. A separate decoder hands it 16-bit payloads that already carry a word-kind tag. The block picks out command words addressed to its own terminal and decodes the direction bit, subaddress and word count. It then runs a plain memory-mapped master port: one strobe per beat, held until the slave drops its wait signal.

For a receive command, each following data word is written to memory, and the block then answers with a status word. For a transmit command, it answers with a status word first and then streams the words it reads from memory. Mode commands get a status word with the error flag set and cause no memory traffic. A receive transfer that stalls is abandoned after a programmable gap. Command, data and status words all pass through a single 16-bit word register, because the terminal only ever speaks in reply to the controller. Each accepted command, and each abort, raises a one-cycle interrupt pulse whose number comes from the flags of the status word being built.

Top module: `mem_bridge`

## Requirements
- R1: The word-kind code on `rx_kind` and `tx_kind` is 0 for data, 1 for command and 2 for status. While idle, a command word is accepted only if bits 15:11 equal `TERM_ADDR`. Any other command word causes no interrupt, no output word and no memory access.
- R2: Command word fields are laid out as bit 10 for direction (1 = transmit), bits 9:5 for subaddress and bits 4:0 for word count. A count of 0 means 32 words.
- R3: In a receive transfer, data word k (counting from 0) is written to address subaddress*32 + k. The index advances only when a beat completes, which is a strobe sampled with `m_wait` low. Address and write data hold steady while `m_wait` is high.
- R4: When a receive transfer has all its words, the block emits one status word (kind 2). Its value is `TERM_ADDR` in bits 15:11, bit 10 (error) = 0, bit 9 = 0, bit 8 (service) = 1 and bits 7:0 = 0.
- R5: A transmit transfer emits the status word of R4 and then one data word (kind 0) per count. The data words come from consecutive addresses starting at subaddress*32.
- R6: A command with subaddress 0 or 31 emits one status word with error = 1 and service = 0. It makes no memory access.
- R7: Accepting a command raises `irq` for exactly one cycle. At the same time `irq_num` is set to {service, error}: 2'b10 for a normal transfer and 2'b01 for a mode command.
- R8: If no data word arrives for `GAP_CYCLES` cycles while a receive transfer waits, the transfer aborts. Beats already written stay written. The block emits a status word with error = 1 and service = 1, and raises a one-cycle `irq` with `irq_num` = 2'b11.
- R9: Out of reset, and whenever idle, `tx_valid`, `m_read`, `m_write` and `irq` are low. `m_read` and `m_write` are never high together.
- R10: Data words arriving while idle are ignored. Command words arriving during a transfer are also ignored: they produce no extra interrupt and do not disturb the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Decoded word present this cycle |
| rx_kind | input | 2 | Kind of the decoded word (0 data, 1 command, 2 status) |
| rx_word | input | 16 | Payload of the decoded word |
| tx_valid | output | 1 | Word for the encoder present this cycle |
| tx_kind | output | 2 | Kind of the outgoing word |
| tx_word | output | 16 | Payload of the outgoing word |
| m_addr | output | 10 | Memory word address |
| m_read | output | 1 | Read strobe |
| m_write | output | 1 | Write strobe |
| m_wdata | output | 16 | Write data |
| m_rdata | input | 16 | Read data, valid on the beat that completes |
| m_wait | input | 1 | Slave stall; the beat completes when low |
| irq | output | 1 | One-cycle interrupt request |
| irq_num | output | 2 | Interrupt number {service, error} |

## Verification
Some properties are checked by the assertions on every cycle. Read and write strobes stay exclusive. A stalled request keeps its address and data. The word index moves by one per completed beat. The address offset stays below the decoded word count. An interrupt lasts one cycle and follows every accepted command, and only status or data kinds are ever sent. Other behaviour only the bench scenarios can show: the memory contents a receive leaves behind, the order and values of words returned for a transmit, the status and interrupt codes for mode commands and gap aborts, and the silence that follows foreign or out-of-place words.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int WORD_W = 16;
  localparam int TA_W   = 5;
  localparam int SA_W   = 5;
  localparam int WC_W   = 5;
  localparam int TOT_W  = WC_W + 1;
  localparam int ADDR_W = SA_W + WC_W;

  localparam logic [1:0] KIND_DATA = 2'd0;
  localparam logic [1:0] KIND_CMD  = 2'd1;
  localparam logic [1:0] KIND_STAT = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RXW, ST_WR, ST_MKST, ST_SEND_ST, ST_RD, ST_SEND_D
  } br_state_e;

  // word count field to number of words (zero stands for the full block)
  function automatic logic [TOT_W-1:0] word_total(input logic [WC_W-1:0] wc);
    word_total = (wc == '0) ? TOT_W'(1 << WC_W) : {1'b0, wc};
  endfunction

  function automatic logic [ADDR_W-1:0] mem_address(input logic [SA_W-1:0] sa,
                                                    input logic [WC_W-1:0] idx);
    mem_address = {sa, idx};
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic [TA_W-1:0] ta,
                                                    input logic err,
                                                    input logic svc);
    status_word = {ta, err, 1'b0, svc, 8'h00};
  endfunction
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import bridge_pkg::*;
#(
  parameter logic [TA_W-1:0] TERM_ADDR = 5'd1
) (
  input  logic [WORD_W-1:0] word,
  output logic              addr_hit,
  output logic              is_tx,
  output logic [SA_W-1:0]   sa,
  output logic [TOT_W-1:0]  total,
  output logic              is_mode
);
  always_comb begin
    addr_hit = (word[WORD_W-1 -: TA_W] == TERM_ADDR);
    is_tx    = word[SA_W + WC_W];
    sa       = word[WC_W +: SA_W];
    total    = word_total(word[WC_W-1:0]);
    is_mode  = (sa == '0) || (sa == '1);
  end
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int GAP_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(GAP_CYCLES + 1);
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(GAP_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expired)  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/beat_index.sv
module beat_index
  import bridge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [TOT_W-1:0] total,
  output logic [WC_W-1:0]  idx,
  output logic             last
);
  assign last = ({1'b0, idx} == total - TOT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) idx <= '0;
    else if (step)       idx <= idx + WC_W'(1);
  end
endmodule

// File: rtl/mem_bridge.sv
module mem_bridge
  import bridge_pkg::*;
#(
  parameter logic [4:0] TERM_ADDR  = 5'd1,
  parameter int         GAP_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [1:0]  rx_kind,
  input  logic [15:0] rx_word,
  output logic        tx_valid,
  output logic [1:0]  tx_kind,
  output logic [15:0] tx_word,
  output logic [9:0]  m_addr,
  output logic        m_read,
  output logic        m_write,
  output logic [15:0] m_wdata,
  input  logic [15:0] m_rdata,
  input  logic        m_wait,
  output logic        irq,
  output logic [1:0]  irq_num
);
  br_state_e state;
  logic [WORD_W-1:0] wbuf;          // shared buffer for every word kind
  logic              tr_q, err_q, svc_q, fin_q;
  logic [SA_W-1:0]   sa_q;
  logic [TOT_W-1:0]  wtotal;

  logic              dec_hit, dec_tx, dec_mode;
  logic [SA_W-1:0]   dec_sa;
  logic [TOT_W-1:0]  dec_total;
  logic              gap_expired;
  logic [WC_W-1:0]   widx;
  logic              wlast;

  // named events for the checker
  logic cmd_accept, data_in, beat_done;

  cmd_decode #(.TERM_ADDR(TERM_ADDR)) u_dec (
    .word(rx_word), .addr_hit(dec_hit), .is_tx(dec_tx), .sa(dec_sa),
    .total(dec_total), .is_mode(dec_mode)
  );

  gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(state == ST_RXW), .expired(gap_expired)
  );

  beat_index u_idx (
    .clk(clk), .rst_n(rst_n), .clear(cmd_accept), .step(beat_done),
    .total(wtotal), .idx(widx), .last(wlast)
  );

  assign cmd_accept = (state == ST_IDLE) && rx_valid && (rx_kind == KIND_CMD) && dec_hit;
  assign data_in    = rx_valid && (rx_kind == KIND_DATA);
  assign beat_done  = (m_read || m_write) && !m_wait;

  assign tx_valid = (state == ST_SEND_ST) || (state == ST_SEND_D);
  assign tx_kind  = (state == ST_SEND_ST) ? KIND_STAT : KIND_DATA;
  assign tx_word  = wbuf;
  assign m_read   = (state == ST_RD);
  assign m_write  = (state == ST_WR);
  assign m_addr   = mem_address(sa_q, widx);
  assign m_wdata  = wbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wbuf    <= '0;
      tr_q    <= 1'b0;
      err_q   <= 1'b0;
      svc_q   <= 1'b0;
      fin_q   <= 1'b0;
      sa_q    <= '0;
      wtotal  <= TOT_W'(1);
      irq     <= 1'b0;
      irq_num <= 2'b00;
    end else begin
      irq <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_accept) begin
          wbuf    <= rx_word;
          tr_q    <= dec_tx;
          sa_q    <= dec_sa;
          wtotal  <= dec_total;
          err_q   <= dec_mode;
          svc_q   <= !dec_mode;
          irq     <= 1'b1;
          irq_num <= {!dec_mode, dec_mode};
          state   <= (dec_mode || dec_tx) ? ST_MKST : ST_RXW;
        end
        ST_RXW: begin
          if (data_in) begin
            wbuf  <= rx_word;
            state <= ST_WR;
          end else if (gap_expired) begin
            err_q   <= 1'b1;
            irq     <= 1'b1;
            irq_num <= {svc_q, 1'b1};
            state   <= ST_MKST;
          end
        end
        ST_WR: if (beat_done) state <= wlast ? ST_MKST : ST_RXW;
        ST_MKST: begin
          wbuf  <= status_word(TERM_ADDR, err_q, svc_q);
          state <= ST_SEND_ST;
        end
        ST_SEND_ST: state <= (tr_q && !err_q) ? ST_RD : ST_IDLE;
        ST_RD: if (beat_done) begin
          wbuf  <= m_rdata;
          fin_q <= wlast;
          state <= ST_SEND_D;
        end
        ST_SEND_D: state <= fin_q ? ST_IDLE : ST_RD;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bridge_checks.sv
module bridge_checks
  import bridge_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              m_read,
  input logic              m_write,
  input logic              m_wait,
  input logic [9:0]        m_addr,
  input logic [15:0]       m_wdata,
  input logic              tx_valid,
  input logic [1:0]        tx_kind,
  input logic              irq,
  input logic              cmd_accept,
  input logic              beat_done,
  input logic              wlast,
  input logic [WC_W-1:0]   widx,
  input logic [TOT_W-1:0]  wtotal
);
  p_excl_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_read && m_write));

  p_hold_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_write && m_wait) |=> (m_write && $stable(m_addr) && $stable(m_wdata)));

  p_hold_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_read && m_wait) |=> (m_read && $stable(m_addr)));

  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !wlast) |=> (widx == WC_W'($past(widx) + WC_W'(1))));

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_read || m_write) |-> ({1'b0, m_addr[WC_W-1:0]} < wtotal));

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_accept_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> irq);

  p_tx_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_kind == KIND_STAT || tx_kind == KIND_DATA));
endmodule

bind mem_bridge bridge_checks u_checks (
  .clk(clk), .rst_n(rst_n), .m_read(m_read), .m_write(m_write), .m_wait(m_wait),
  .m_addr(m_addr), .m_wdata(m_wdata), .tx_valid(tx_valid), .tx_kind(tx_kind),
  .irq(irq), .cmd_accept(cmd_accept), .beat_done(beat_done), .wlast(wlast),
  .widx(widx), .wtotal(wtotal)
);

// File: tb/tb_mem_bridge.sv
`timescale 1ns/1ps
module tb_mem_bridge;
  localparam logic [4:0] TA  = 5'd9;
  localparam int         GAP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [1:0] rx_kind = 2'd0;
  logic [15:0] rx_word = 16'd0;
  logic tx_valid, m_read, m_write, irq;
  logic [1:0] tx_kind, irq_num;
  logic [15:0] tx_word, m_wdata;
  logic [15:0] m_rdata = 16'd0;
  logic m_wait = 1'b0;
  logic [9:0] m_addr;

  always #2.5 clk = ~clk;

  mem_bridge #(.TERM_ADDR(TA), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_word(rx_word),
    .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_word(tx_word), .m_addr(m_addr),
    .m_read(m_read), .m_write(m_write), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_wait(m_wait), .irq(irq), .irq_num(irq_num)
  );

  // memory model, logs
  logic [15:0] mem [1024];
  int waits = 0, wcnt = 0, beats = 0;
  logic [1:0]  tx_k [64];
  logic [15:0] tx_w [64];
  int n_tx = 0, n_irq = 0;
  logic [1:0] last_num = 2'd0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [15:0] init_val(input int a);
    return 16'(a * 257) ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] rx_val(input int sa, input int i);
    return 16'(sa * 97 + i * 13) ^ 16'h3C5A;
  endfunction
  function automatic logic [15:0] stat(input bit err, input bit svc);
    return 16'((int'(TA) << 11) | (int'(err) << 10) | (int'(svc) << 8));
  endfunction
  function automatic logic [15:0] cmd(input logic [4:0] ta, input bit tr,
                                      input int sa, input int wc);
    return 16'((int'(ta) << 11) | (int'(tr) << 10) | ((sa % 32) << 5) | (wc % 32));
  endfunction

  always @(negedge clk) begin
    if (m_read || m_write) begin
      if (wcnt < waits) begin m_wait = 1'b1; wcnt++; end
      else begin
        m_wait = 1'b0; wcnt = 0; beats++;
        if (m_write) mem[m_addr] = m_wdata;
        m_rdata = mem[m_addr];
      end
    end else begin m_wait = 1'b0; wcnt = 0; end
    if (tx_valid && n_tx < 64) begin tx_k[n_tx] = tx_kind; tx_w[n_tx] = tx_word; n_tx++; end
    if (irq) begin n_irq++; last_num = irq_num; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [15:0] w);
    @(negedge clk); rx_valid = 1'b1; rx_kind = k; rx_word = w;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_logs();
    n_tx = 0; n_irq = 0;
  endtask

  // {waits[12:11], tr[10], sa[9:5], wc[4:0]}
  localparam logic [12:0] VEC [6] = '{
    {2'd2, 1'b0, 5'd3,  5'd4},
    {2'd0, 1'b1, 5'd3,  5'd4},
    {2'd1, 1'b0, 5'd7,  5'd1},
    {2'd0, 1'b1, 5'd30, 5'd2},
    {2'd0, 1'b0, 5'd12, 5'd0},
    {2'd1, 1'b1, 5'd12, 5'd0}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = init_val(a);
    idle(4);
    // R9: reset state
    chk({tx_valid, m_read, m_write, irq} == 4'b0, "R9 reset outputs",
        int'({tx_valid, m_read, m_write, irq}), 0);
    rst_n = 1'b1;
    idle(2);

    // table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < 6; v++) begin
      automatic bit tr = VEC[v][10];
      automatic int sa = int'(VEC[v][9:5]);
      automatic int wc = int'(VEC[v][4:0]);
      automatic int n  = (wc == 0) ? 32 : wc;
      automatic int bad_words = 0;
      waits = int'(VEC[v][12:11]);
      clear_logs();
      send(2'd1, cmd(TA, tr, sa, wc));
      if (!tr)
        for (int i = 0; i < n; i++) begin idle(7); send(2'd0, rx_val(sa, i)); end
      idle(200);
      chk(n_irq == 1 && last_num == 2'b10, "R7 irq on accept", n_irq * 16 + last_num, 16 + 2);
      if (!tr) begin
        chk(n_tx == 1, "R4 one status word", n_tx, 1);
        chk(tx_k[0] == 2'd2 && tx_w[0] == stat(0, 1), "R4 status value", tx_w[0], stat(0, 1));
        for (int i = 0; i < n; i++) if (mem[sa * 32 + i] != rx_val(sa, i)) bad_words++;
        chk(bad_words == 0, "R3 written words (R2 count)", bad_words, 0);
      end else begin
        chk(n_tx == n + 1, "R5 word count (R2)", n_tx, n + 1);
        chk(tx_k[0] == 2'd2 && tx_w[0] == stat(0, 1), "R5 status first", tx_w[0], stat(0, 1));
        for (int i = 0; i < n && i + 1 < 64; i++)
          if (tx_k[i + 1] != 2'd0 || tx_w[i + 1] != mem[sa * 32 + i]) bad_words++;
        chk(bad_words == 0, "R5 data words", bad_words, 0);
      end
    end
    waits = 1;

    // R1: command for another terminal
    begin
      automatic int b0 = beats;
      clear_logs();
      send(2'd1, cmd(5'd4, 1'b1, 5, 3));
      idle(60);
      chk(n_irq == 0 && n_tx == 0 && beats == b0, "R1 foreign command ignored",
          n_irq + n_tx + beats - b0, 0);
    end

    // R10: data word while idle
    begin
      automatic int b0 = beats;
      clear_logs();
      send(2'd0, 16'hBEEF);
      idle(30);
      chk(n_tx == 0 && beats == b0, "R10 idle data ignored", n_tx + beats - b0, 0);
    end

    // R6: mode commands, subaddress 0 (transmit) and 31 (receive)
    for (int m = 0; m < 2; m++) begin
      automatic int b0 = beats;
      clear_logs();
      send(2'd1, cmd(TA, m == 0, (m == 0) ? 0 : 31, 2));
      idle(60);
      chk(n_tx == 1 && tx_k[0] == 2'd2 && tx_w[0] == stat(1, 0), "R6 mode status",
          tx_w[0], stat(1, 0));
      chk(beats == b0, "R6 no memory access", beats - b0, 0);
      chk(n_irq == 1 && last_num == 2'b01, "R7 mode irq number", last_num, 1);
    end

    // R8: gap timeout after two of five words
    clear_logs();
    send(2'd1, cmd(TA, 1'b0, 20, 5));
    idle(7); send(2'd0, rx_val(20, 0));
    idle(7); send(2'd0, rx_val(20, 1));
    idle(100);
    chk(n_tx == 1 && tx_w[0] == stat(1, 1), "R8 abort status", tx_w[0], stat(1, 1));
    chk(n_irq == 2 && last_num == 2'b11, "R8 abort irq", n_irq * 16 + last_num, 32 + 3);
    chk(mem[640] == rx_val(20, 0) && mem[641] == rx_val(20, 1), "R8 kept writes",
        mem[641], rx_val(20, 1));
    chk(mem[642] == init_val(642), "R8 no later write", mem[642], init_val(642));

    // R10: command in the middle of a receive transfer
    clear_logs();
    send(2'd1, cmd(TA, 1'b0, 21, 2));
    idle(7); send(2'd0, rx_val(21, 0));
    idle(3); send(2'd1, cmd(TA, 1'b1, 21, 1));
    idle(3); send(2'd0, rx_val(21, 1));
    idle(60);
    chk(n_irq == 1, "R10 no extra irq", n_irq, 1);
    chk(n_tx == 1 && tx_w[0] == stat(0, 1), "R10 transfer intact", tx_w[0], stat(0, 1));
    chk(mem[673] == rx_val(21, 1), "R10 second word", mem[673], rx_val(21, 1));

    // R9: quiet after everything
    chk({tx_valid, m_read, m_write, irq} == 4'b0, "R9 idle outputs",
        int'({tx_valid, m_read, m_write, irq}), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule